// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs single read and write cycles on an external bus where the low sixteen address bits and the data share one set of AD lines, for one chip-select region. An internal requester presents an address, write data, two byte enables and a read/write flag for one clock. The block then drives the external strobes: an address-latch pulse, read, write, separate low-byte and high-byte write strobes, and the chip select. It also drives the AD lines with an output enable and holds the upper address bits on dedicated pins. When the access is over it returns a one-cycle done pulse, together with the read data.

Configuration inputs set the bus width (16 or 8 bits), a 4-bit wait code and a 2-bit read-recovery code. The wait code either gives a fixed number of wait cycles or selects an externally stretched mode that follows the WAIT input. The recovery code adds idle cycles after each read, with the bus released. On the 8-bit bus, a request with both byte enables set runs as two bus cycles: the low byte at the even address first, then the high byte at the odd address. The configuration is sampled when a request is accepted. The chip select stays off until it is enabled.

Top module: `muxBusCtl`

## Requirements
- R1: While reset is held and right after it, busAle, busCs, busRd, busWr, busWrLo, busWrHi, adOe and reqDone are all 0.
- R2: busCs is 1 in every address cycle and strobe cycle of an access when csEnable is 1, and it is 0 in every other cycle. With csEnable 0 it never rises.
- R3: Each bus cycle starts with exactly one busAle cycle with adOe 1. In that cycle adOut carries reqAddr[15:1] and, in bit 0, 0 on the 16-bit bus or the byte lane on the 8-bit bus. During the access, addrHi carries reqAddr above bit 15.
- R4: Wait codes 0000 to 0111 (value W) make each read or write strobe last exactly 1+W cycles, whatever waitIn does.
- R5: Wait code 1111 makes the strobe last 2+N cycles. N counts the consecutive cycles, from the second strobe cycle on, that end with waitIn at 1.
- R6: After each read strobe, recovery code 00 inserts 2 idle cycles, 01 inserts 1 and 10 inserts 0. An idle cycle has busCs, busRd and adOe at 0, and these cycles come before the next busAle or before reqDone.
- R7: adOe is 0 in every cycle with busRd at 1. Read data is taken from adIn in the last read cycle. reqRdata holds byte 1 and byte 0 of the access, and a disabled byte reads as 0.
- R8: On the 16-bit bus (cfgNarrow 0), a write drives adOe 1 and adOut with reqWdata during the strobe, with busWrLo = reqBe[0] and busWrHi = reqBe[1].
- R9: On the 8-bit bus (cfgNarrow 1), reqBe 11 runs two bus cycles: lane 0 carries the low byte, then lane 1 carries the high byte. reqBe 01 runs lane 0 only and 10 runs lane 1 only. Write bytes appear on adOut[7:0] with busWrLo 1 and busWrHi 0.
- R10: reqDone is a single-cycle pulse. Counting from the first cycle after acceptance as cycle 1, it comes in cycle H*(1+S+Rc)+1, where H is the number of bus cycles, S the strobe length and Rc the recovery length (0 for writes).
- R11: A request with a wait code from 1000 to 1110, recovery code 11, cfgMode other than 00, or reqBe 00 produces no bus cycle. Its reqDone comes in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgNarrow | input | 1 | 0: 16-bit data bus, 1: 8-bit data bus |
| cfgWait | input | 4 | Wait code |
| cfgRecov | input | 2 | Read-recovery code |
| cfgMode | input | 2 | Waveform select, only 00 legal |
| csEnable | input | 1 | Enables the chip-select output |
| reqValid | input | 1 | One-cycle request while idle |
| reqWrite | input | 1 | 1: write, 0: read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables |
| reqDone | output | 1 | Access complete pulse |
| reqRdata | output | 16 | Read data, valid with reqDone |
| busAle | output | 1 | Address latch enable |
| busCs | output | 1 | Chip select |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWrLo | output | 1 | Low-byte write strobe |
| busWrHi | output | 1 | High-byte write strobe |
| addrHi | output | ADDR_W-16 | Non-multiplexed upper address |
| adOut | output | 16 | AD output value |
| adOe | output | 1 | AD output enable |
| adIn | input | 16 | AD input value |
| waitIn | input | 1 | External wait request |

## Verification
Every output is registered. An access accepted at one edge shows its address cycle in the next cycle, and its strobe, recovery and done cycles follow in the order R10 gives. The bench drives inputs and samples outputs on the falling edge. It counts each phase against lengths worked out from the codes, and it derives the expected done cycle from the same formula. waitIn is driven per strobe cycle, so the external extension is known in advance. Read data and the done pulse are compared in the done cycle, and the pulse is checked again one cycle later.

// File: rtl/muxBusPkg.sv
package muxBusPkg;
  localparam int AD_W = 16;
  localparam logic [3:0] WAIT_EXT = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_STRB, ST_RECOV, ST_DONE
  } busState_e;

  typedef struct packed {
    logic load;       // latch the request
    logic addrPhase;  // drive address on AD
    logic wrPhase;    // drive write data, write strobe active
    logic capture;    // take read data from AD
    logic narrow;     // 8-bit bus for this access
    logic laneHi;     // current byte lane on the 8-bit bus
  } dpCtl_t;
endpackage

// File: rtl/muxBusCtrl.sv
module muxBusCtrl
  import muxBusPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgNarrow,
  input  logic [3:0] cfgWait,
  input  logic [1:0] cfgRecov,
  input  logic [1:0] cfgMode,
  input  logic       csEnable,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqBe,
  input  logic       waitIn,
  output logic       busAle,
  output logic       busCs,
  output logic       busRd,
  output logic       busWr,
  output logic       adOe,
  output logic       reqDone,
  output dpCtl_t     dpCtl
);
  busState_e state;
  logic [2:0] cnt;
  logic [2:0] waitQ;
  logic [1:0] recovQ;
  logic narrowQ, extQ, csEnQ, writeQ, laneHiQ, pendQ;
  logic legal, strbEnd, strbLast, holdWait;
  logic [1:0] recovLen;

  always_comb begin
    legal = (!cfgWait[3] || cfgWait == WAIT_EXT) && cfgRecov != 2'b11 &&
            cfgMode == 2'b00 && reqBe != 2'b00;
    case (recovQ)
      2'b00:   recovLen = 2'd2;
      2'b01:   recovLen = 2'd1;
      default: recovLen = 2'd0;
    endcase
    holdWait = extQ && waitIn;
    strbEnd  = (state == ST_STRB) && cnt == 3'd0;
    strbLast = strbEnd && !holdWait;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      waitQ   <= '0;
      recovQ  <= '0;
      narrowQ <= 1'b0;
      extQ    <= 1'b0;
      csEnQ   <= 1'b0;
      writeQ  <= 1'b0;
      laneHiQ <= 1'b0;
      pendQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          if (legal) begin
            narrowQ <= cfgNarrow;
            extQ    <= cfgWait == WAIT_EXT;
            waitQ   <= cfgWait[2:0];
            recovQ  <= cfgRecov;
            csEnQ   <= csEnable;
            writeQ  <= reqWrite;
            laneHiQ <= cfgNarrow && reqBe == 2'b10;
            pendQ   <= cfgNarrow && reqBe == 2'b11;
            state   <= ST_ADDR;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_ADDR: begin
          cnt   <= extQ ? 3'd1 : waitQ;
          state <= ST_STRB;
        end
        ST_STRB: begin
          if (cnt != 3'd0) begin
            cnt <= cnt - 3'd1;
          end else if (!holdWait) begin
            if (!writeQ && recovLen != 2'd0) begin
              cnt   <= 3'(recovLen - 2'd1);
              state <= ST_RECOV;
            end else if (pendQ) begin
              pendQ   <= 1'b0;
              laneHiQ <= 1'b1;
              state   <= ST_ADDR;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_RECOV: begin
          if (cnt != 3'd0) begin
            cnt <= cnt - 3'd1;
          end else if (pendQ) begin
            pendQ   <= 1'b0;
            laneHiQ <= 1'b1;
            state   <= ST_ADDR;
          end else begin
            state <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busAle  = state == ST_ADDR;
    busRd   = state == ST_STRB && !writeQ;
    busWr   = state == ST_STRB && writeQ;
    busCs   = csEnQ && (state == ST_ADDR || state == ST_STRB);
    adOe    = state == ST_ADDR || (state == ST_STRB && writeQ);
    reqDone = state == ST_DONE;
    dpCtl.load      = state == ST_IDLE && reqValid && legal;
    dpCtl.addrPhase = busAle;
    dpCtl.wrPhase   = busWr;
    dpCtl.capture   = strbLast && !writeQ;
    dpCtl.narrow    = narrowQ;
    dpCtl.laneHi    = laneHiQ;
  end

  AST_ALE_SOLO: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> !busRd && !busWr);                                   // R3
  AST_CS_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busCs |-> busAle || busRd || busWr);                            // R2
  AST_RD_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> !adOe);                                               // R7
  AST_RECOV_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RECOV |-> !adOe && !busCs && !busRd && !busWr);     // R6
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strbEnd && extQ && waitIn |=> state == ST_STRB);                // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);                                          // R10
endmodule

// File: rtl/muxBusDp.sv
module muxBusDp
  import muxBusPkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int HI_W = ADDR_W - AD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [AD_W-1:0]   reqWdata,
  input  logic [1:0]        reqBe,
  input  logic [AD_W-1:0]   adIn,
  output logic [AD_W-1:0]   adOut,
  output logic [HI_W-1:0]   addrHi,
  output logic              busWrLo,
  output logic              busWrHi,
  output logic [AD_W-1:0]   reqRdata
);
  localparam int BYTE_W = AD_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [AD_W-1:0]   wdataQ;
  logic [AD_W-1:0]   rdataQ;
  logic [1:0]        beQ;
  logic [BYTE_W-1:0] laneByte;
  logic [AD_W-1:0]   beMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      beQ    <= '0;
    end else if (dpCtl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      rdataQ <= '0;
    end else if (dpCtl.capture) begin
      if (!dpCtl.narrow)
        rdataQ <= adIn & beMask;
      else if (dpCtl.laneHi)
        rdataQ[AD_W-1:BYTE_W] <= adIn[BYTE_W-1:0];
      else
        rdataQ[BYTE_W-1:0] <= adIn[BYTE_W-1:0];
    end
  end

  always_comb begin
    beMask   = {{BYTE_W{beQ[1]}}, {BYTE_W{beQ[0]}}};
    laneByte = dpCtl.laneHi ? wdataQ[AD_W-1:BYTE_W] : wdataQ[BYTE_W-1:0];
    if (dpCtl.addrPhase)
      adOut = {addrQ[AD_W-1:1], dpCtl.narrow && dpCtl.laneHi};
    else if (dpCtl.wrPhase)
      adOut = dpCtl.narrow ? {{BYTE_W{1'b0}}, laneByte} : wdataQ;
    else
      adOut = '0;
    addrHi   = addrQ[ADDR_W-1:AD_W];
    busWrLo  = dpCtl.wrPhase && (dpCtl.narrow || beQ[0]);
    busWrHi  = dpCtl.wrPhase && !dpCtl.narrow && beQ[1];
    reqRdata = rdataQ;
  end

  AST_NARROW_NO_HI: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.narrow && dpCtl.wrPhase |-> !busWrHi);                    // R9
  AST_STROBE_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    busWrLo || busWrHi |-> dpCtl.wrPhase);                          // R8
endmodule

// File: rtl/muxBusCtl.sv
module muxBusCtl
  import muxBusPkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgNarrow,
  input  logic [3:0]             cfgWait,
  input  logic [1:0]             cfgRecov,
  input  logic [1:0]             cfgMode,
  input  logic                   csEnable,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [15:0]            reqWdata,
  input  logic [1:0]             reqBe,
  output logic                   reqDone,
  output logic [15:0]            reqRdata,
  output logic                   busAle,
  output logic                   busCs,
  output logic                   busRd,
  output logic                   busWr,
  output logic                   busWrLo,
  output logic                   busWrHi,
  output logic [ADDR_W-17:0]     addrHi,
  output logic [15:0]            adOut,
  output logic                   adOe,
  input  logic [15:0]            adIn,
  input  logic                   waitIn
);
  dpCtl_t dpCtl;

  muxBusCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgNarrow(cfgNarrow), .cfgWait(cfgWait),
    .cfgRecov(cfgRecov), .cfgMode(cfgMode), .csEnable(csEnable),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBe(reqBe),
    .waitIn(waitIn), .busAle(busAle), .busCs(busCs), .busRd(busRd),
    .busWr(busWr), .adOe(adOe), .reqDone(reqDone), .dpCtl(dpCtl)
  );

  muxBusDp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .adIn(adIn), .adOut(adOut),
    .addrHi(addrHi), .busWrLo(busWrLo), .busWrHi(busWrHi),
    .reqRdata(reqRdata)
  );
endmodule

// File: tb/muxBusCtl_tb.sv
module muxBusCtl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgNarrow = 1'b0, csEnable = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0] cfgWait = '0;
  logic [1:0] cfgRecov = '0, cfgMode = '0, reqBe = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, adIn = '0;
  logic waitIn = 1'b0;
  logic reqDone, busAle, busCs, busRd, busWr, busWrLo, busWrHi, adOe;
  logic [15:0] reqRdata, adOut;
  logic [ADDR_W-17:0] addrHi;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  muxBusCtl #(.ADDR_W(ADDR_W)) dut_i (.*);

  // monitor state
  int aleCnt, curHalf, strbCur, extN, oeViol, csViol;
  int latched[2], hiSeen[2], strbLen[2], gap[2], wdSeen[2], wloSeen[2], whiSeen[2];
  logic gapping, prevRd, csExp;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return 8'(a[7:0] * 8'd7 + a[15:8] + 8'd3);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busAle) begin
      aleCnt++;
      curHalf = (aleCnt > 1) ? 1 : 0;
      latched[curHalf] = int'(adOut);
      hiSeen[curHalf] = int'(addrHi);
      strbCur = 0;
      if (!adOe) oeViol++;
    end
    if (busRd && adOe) oeViol++;
    if ((busAle || busRd || busWr) && busCs != csExp) csViol++;
    if (!(busAle || busRd || busWr) && busCs) csViol++;
    if (gapping) begin
      if (busAle || reqDone) gapping = 1'b0;
      else begin
        gap[curHalf]++;
        if (adOe || busCs || busRd) oeViol++;
      end
    end
    if (prevRd && !busRd && !busAle && !reqDone) begin
      gapping = 1'b1;
      gap[curHalf]++;
      if (adOe || busCs) oeViol++;
    end
    prevRd = busRd;
    waitIn = (busRd || busWr) && strbCur >= 1 && strbCur <= extN;
    if (busRd || busWr) begin
      if (strbCur == 0) begin
        wdSeen[curHalf]  = int'(adOut);
        wloSeen[curHalf] = int'(busWrLo);
        whiSeen[curHalf] = int'(busWrHi);
        if (busWr && !adOe) oeViol++;
      end
      strbCur++;
      strbLen[curHalf] = strbCur;
    end
    if (busRd) begin
      if (cfgNarrow) adIn = {8'h00, memByte(16'(latched[curHalf]))};
      else adIn = {memByte(16'(latched[curHalf]) | 16'h1),
                   memByte(16'(latched[curHalf]) & 16'hFFFE)};
    end else adIn = 16'h0;
  end

  task automatic runAccess(input logic nar, input logic [3:0] w, input logic [1:0] rc,
                           input logic [1:0] md, input logic wr, input logic [1:0] be,
                           input logic [ADDR_W-1:0] a, input logic [15:0] wd,
                           input int en, input logic cse);
    bit legal;
    int halves, s, rr, expC, c, lane;
    logic [15:0] expRd;
    @(negedge clk);
    aleCnt = 0; curHalf = 0; strbCur = 0; gapping = 1'b0; oeViol = 0; csViol = 0;
    for (int h = 0; h < 2; h++) begin
      latched[h] = -1; hiSeen[h] = -1; strbLen[h] = 0; gap[h] = 0;
      wdSeen[h] = -1; wloSeen[h] = -1; whiSeen[h] = -1;
    end
    extN = en; csExp = cse;
    cfgNarrow = nar; cfgWait = w; cfgRecov = rc; cfgMode = md; csEnable = cse;
    reqWrite = wr; reqBe = be; reqAddr = a; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    c = 1;
    while (!reqDone && c < 400) begin
      @(negedge clk);
      c++;
    end
    #1;
    legal = (w < 8 || w == 4'hF) && rc != 2'b11 && md == 2'b00 && be != 2'b00;
    halves = !legal ? 0 : (nar && be == 2'b11) ? 2 : 1;
    s = (w == 4'hF) ? 2 + en : 1 + int'(w);
    rr = wr ? 0 : (rc == 2'b00) ? 2 : (rc == 2'b01) ? 1 : 0;
    expC = halves * (1 + s + rr) + 1;
    if (legal) begin
      chk("R10 done cycle", c, expC);
      chk("R3/R9 address cycles", aleCnt, halves);
    end else begin
      chk("R11 illegal done cycle", c, 1);
      chk("R11 illegal no bus cycle", aleCnt, 0);
    end
    chk("R2 chip select", csViol, 0);
    chk("R7/R6 bus release", oeViol, 0);
    for (int h = 0; h < halves; h++) begin
      lane = nar ? ((be == 2'b10) ? 1 : h) : 0;
      chk("R3 latched address", latched[h], int'({a[15:1], 1'(lane)}));
      chk("R3 upper address", hiSeen[h], int'(a[ADDR_W-1:16]));
      chk(w == 4'hF ? "R5 stretched strobe" : "R4 fixed strobe", strbLen[h], s);
      if (!wr) chk("R6 recovery", gap[h], rr);
      if (wr && !nar) begin
        chk("R8 write data", wdSeen[h], int'(wd));
        chk("R8 low strobe", wloSeen[h], int'(be[0]));
        chk("R8 high strobe", whiSeen[h], int'(be[1]));
      end
      if (wr && nar) begin
        chk("R9 byte data", wdSeen[h] & 255, int'(lane ? wd[15:8] : wd[7:0]));
        chk("R9 low strobe", wloSeen[h], 1);
        chk("R9 high strobe", whiSeen[h], 0);
      end
    end
    if (legal && !wr) begin
      expRd = {be[1] ? memByte(a[15:0] | 16'h1) : 8'h00,
               be[0] ? memByte(a[15:0] & 16'hFFFE) : 8'h00};
      chk("R7 read data", int'(reqRdata), int'(expRd));
    end
    @(negedge clk);
    chk("R10 single pulse", int'(reqDone), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int idx;
    logic [3:0] w;
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", int'({busAle, busCs, busRd, busWr, busWrLo, busWrHi}), 0);
    chk("R1 oe and done in reset", int'({adOe, reqDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", int'({busAle, busCs, busRd, busWr, busWrLo, busWrHi}), 0);
    chk("R1 oe and done after reset", int'({adOe, reqDone}), 0);
    idx = 0;
    for (int nar = 0; nar < 2; nar++)
      for (int wi = 0; wi < 9; wi++)
        for (int rc = 0; rc < 3; rc++)
          for (int wr = 0; wr < 2; wr++)
            for (int be = 1; be < 4; be++) begin
              w = (wi == 8) ? 4'hF : 4'(wi);
              runAccess(1'(nar), w, 2'(rc), 2'b00, 1'(wr), 2'(be),
                        ADDR_W'(idx * 32'h1_3579), 16'(idx * 16'h3B1D + 16'h0C5A),
                        idx % 4, 1'b1);
              idx++;
            end
    // R11 illegal settings
    for (int wi = 8; wi < 15; wi++)
      runAccess(1'b0, 4'(wi), 2'b01, 2'b00, 1'b0, 2'b11, 20'h1_2344, 16'h0, 0, 1'b1);
    runAccess(1'b1, 4'h2, 2'b11, 2'b00, 1'b0, 2'b11, 20'h2_0002, 16'h0, 0, 1'b1);
    for (int md = 1; md < 4; md++)
      runAccess(1'b0, 4'h1, 2'b10, 2'(md), 1'b1, 2'b11, 20'h3_0010, 16'hBEEF, 0, 1'b1);
    runAccess(1'b0, 4'h1, 2'b10, 2'b00, 1'b1, 2'b00, 20'h3_0010, 16'hBEEF, 0, 1'b1);
    // R2 chip select kept off
    runAccess(1'b0, 4'h3, 2'b01, 2'b00, 1'b0, 2'b11, 20'hA_5556, 16'h0, 0, 1'b0);
    runAccess(1'b1, 4'hF, 2'b00, 2'b00, 1'b1, 2'b11, 20'h5_AAA8, 16'h1234, 2, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule